// File: doc/BRIEF.md
# Indirect Pointer Address Unit

This block works out the data-memory address for the indirect load and store operations of a small 8-bit processor core. The operations address memory through one of three 16-bit register-pair pointers. The instruction decoder pulses `start` and presents the following:

- the current pointer value;
- which pair it came from;
- an addressing mode;
- a 6-bit offset;
- the data register involved;
- whether the access is a store.

One cycle later the unit presents its results:

- the memory address and an access strobe;
- the new low and high pointer bytes, each with its own write enable and target register index;
- the number of cycles the operation costs;
- a flag marking operations whose result is undefined.

Two static inputs configure the unit. The first is a 16-bit data-space mask. Every pointer is ANDed with this mask before it reaches memory, so a small part only sees the address bits it implements. On parts whose mask is no greater than 0x00FF, the high pointer register is never rewritten by an increment or decrement. The second is a core-variant code, which selects the cycle-count table.

Top module: `ptr_addr_unit`

## Requirements
- R1: In plain mode (mode 0), the address is `ptrIn & dataMask`. The low and high bytes presented for writeback equal `ptrIn`, and both write enables stay low.
- R2: In pre-decrement mode (mode 1), the pointer is reduced by one modulo 2^16 first. The address is that reduced value ANDed with the mask, and the reduced value is presented for writeback.
- R3: In post-increment mode (mode 2), the address is the original pointer ANDed with the mask. The pointer plus one, modulo 2^16, is presented for writeback.
- R4: In offset mode (mode 3) with pair Y (select 1) or Z (select 2), the address is `(ptrIn & dataMask) + disp` modulo 2^16, and no write enable is raised.
- R5: Offset mode with pair X (select 0), or any operation with select 3, is invalid. Such an operation gives `done` high, `memStrobe` low, `undefOp` high, `cycles` 0 and both write enables low. The address, writeback bytes, register indices and `memWrite` keep their previous values.
- R6: In modes 1 and 2 the low write enable is raised. The high write enable is raised only when `dataMask` is greater than 0x00FF.
- R7: The writeback register indices are 26/27 for X, 28/29 for Y and 30/31 for Z, with the low byte going to the even index.
- R8: `undefOp` is raised in two cases where `dataReg` is one of the selected pair's two register indices: a post-increment load (`isStore` 0), or a pre-decrement or post-increment store (`isStore` 1). It is low for every other valid operation.
- R9: `cycles` depends on the operation and the core variant. Variant codes are 0 standard, 1 reduced, 2 extended, and 3 behaves as standard.
  - Plain mode: 1 on reduced or extended, otherwise 2.
  - Pre-decrement load: 3 on reduced, otherwise 2.
  - Pre-decrement store: always 2.
  - Post-increment load: 1 on extended, otherwise 2.
  - Post-increment store: 1 on reduced or extended, otherwise 2.
  - Offset mode: always 2.
- R10: Outputs update in the cycle after `start` is sampled high. `done` is high for exactly that cycle per start. In a cycle after `start` was low, `done`, `memStrobe`, both write enables and `undefOp` are low, and all other outputs hold their values.
- R11: While in reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, one cycle |
| ptrSel | input | 2 | Pointer pair: 0 X, 1 Y, 2 Z |
| mode | input | 2 | 0 plain, 1 pre-decrement, 2 post-increment, 3 offset |
| isStore | input | 1 | 1 for store, 0 for load |
| dataReg | input | 5 | Index of the data register being loaded or stored |
| ptrIn | input | 16 | Current pointer pair value |
| disp | input | 6 | Unsigned offset for mode 3 |
| dataMask | input | 16 | Implemented data-space mask (static) |
| coreVariant | input | 2 | Cycle-table variant (static) |
| memAddr | output | 16 | Data-memory address |
| memStrobe | output | 1 | Memory access request |
| memWrite | output | 1 | Access is a write |
| ptrLoData | output | 8 | New low pointer byte |
| ptrHiData | output | 8 | New high pointer byte |
| ptrLoWe | output | 1 | Write enable, low pointer register |
| ptrHiWe | output | 1 | Write enable, high pointer register |
| ptrLoIdx | output | 5 | Register index for the low byte |
| ptrHiIdx | output | 5 | Register index for the high byte |
| cycles | output | 2 | Cycle cost of the operation |
| undefOp | output | 1 | Undefined or invalid operation |
| done | output | 1 | Results valid, one cycle |

## Verification
The bench builds the unit with its default parameters: a 16-bit pointer, a 6-bit offset and a pointer base register of 26. With these values, pointers at 0x0000 and 0xFFFF reach the wrap in both directions, and an offset of 63 on top of a masked pointer near the top of the space reaches the address carry wrap. Masks of 0x00FF and 0x00DF against 0x01FF and 0xFFFF put both high-byte writeback regimes within reach. The full 5-bit data register range hits all six pointer register indices.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  localparam int PTR_W  = 16;
  localparam int DISP_W = 6;
  localparam int RIDX_W = 5;
  localparam int CYC_W  = 2;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'd0,
    MODE_PREDEC = 2'd1,
    MODE_POSTINC= 2'd2,
    MODE_OFFSET = 2'd3
  } addrMode_e;

  typedef enum logic [1:0] {
    PAIR_X   = 2'd0,
    PAIR_Y   = 2'd1,
    PAIR_Z   = 2'd2,
    PAIR_BAD = 2'd3
  } ptrPair_e;

  typedef enum logic [1:0] {
    CORE_STD  = 2'd0,
    CORE_RED  = 2'd1,
    CORE_EXT  = 2'd2,
    CORE_ALT  = 2'd3
  } coreKind_e;

  typedef struct packed {
    logic             doDec;
    logic             doInc;
    logic             useDisp;
    logic             invalid;
    logic             undefChk;
    logic [CYC_W-1:0] cycles;
  } ctrlStrobes_t;
endpackage

// File: rtl/ptr_addr_ctrl.sv
module ptr_addr_ctrl
  import ptr_addr_pkg::*;
#(
  parameter int CYCW = CYC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [1:0]   ptrSel,
  input  logic [1:0]   coreVariant,
  input  logic         isStore,
  output ctrlStrobes_t strb
);
  addrMode_e modeE;
  coreKind_e kindE;
  logic isRed;
  logic isExt;
  logic [CYCW-1:0] cyc;

  assign modeE = addrMode_e'(mode);
  assign kindE = coreKind_e'(coreVariant);
  assign isRed = (kindE == CORE_RED);
  assign isExt = (kindE == CORE_EXT);

  always_comb begin
    strb = '0;
    cyc  = CYCW'(2);
    unique case (modeE)
      MODE_PLAIN:   cyc = (isRed || isExt) ? CYCW'(1) : CYCW'(2);
      MODE_PREDEC: begin
        strb.doDec    = 1'b1;
        strb.undefChk = isStore;
        cyc = isStore ? CYCW'(2) : (isRed ? CYCW'(3) : CYCW'(2));
      end
      MODE_POSTINC: begin
        strb.doInc    = 1'b1;
        strb.undefChk = 1'b1;
        if (isStore) cyc = (isRed || isExt) ? CYCW'(1) : CYCW'(2);
        else         cyc = isExt ? CYCW'(1) : CYCW'(2);
      end
      MODE_OFFSET: begin
        strb.useDisp = 1'b1;
        cyc = CYCW'(2);
      end
      default: cyc = CYCW'(2);
    endcase
    strb.invalid = (ptrPair_e'(ptrSel) == PAIR_BAD) ||
                   (modeE == MODE_OFFSET && ptrPair_e'(ptrSel) == PAIR_X);
    strb.cycles  = strb.invalid ? '0 : cyc;
  end

  // R9: a valid request never costs zero cycles
  p_valid_cost_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !strb.invalid) |-> (strb.cycles != '0));
  // R2 R3 R4: at most one pointer adjustment per request
  p_one_adjust_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |-> $onehot0({strb.doDec, strb.doInc, strb.useDisp}));
endmodule

// File: rtl/ptr_addr_dp.sv
module ptr_addr_dp
  import ptr_addr_pkg::*;
#(
  parameter int PW       = PTR_W,
  parameter int DW       = DISP_W,
  parameter int RW       = RIDX_W,
  parameter int CYCW     = CYC_W,
  parameter int PTR_BASE = 26
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  ctrlStrobes_t  strb,
  input  logic [1:0]    ptrSel,
  input  logic          isStore,
  input  logic [RW-1:0] dataReg,
  input  logic [PW-1:0] ptrIn,
  input  logic [DW-1:0] disp,
  input  logic [PW-1:0] dataMask,
  output logic [PW-1:0] memAddr,
  output logic          memStrobe,
  output logic          memWrite,
  output logic [7:0]    ptrLoData,
  output logic [7:0]    ptrHiData,
  output logic          ptrLoWe,
  output logic          ptrHiWe,
  output logic [RW-1:0] ptrLoIdx,
  output logic [RW-1:0] ptrHiIdx,
  output logic [CYCW-1:0] cycles,
  output logic          undefOp,
  output logic          done
);
  localparam int HB = PW - 8;
  localparam logic [PW-1:0] LOW_SPACE = PW'(8'hFF);

  logic [PW-1:0] nextPtr;
  logic [PW-1:0] accBase;
  logic [PW-1:0] masked;
  logic [PW-1:0] addrNext;
  logic [RW-1:0] loIdx;
  logic [RW-1:0] hiIdx;
  logic          hitsPair;
  logic          wideSpace;
  logic          adjust;

  always_comb begin
    nextPtr = ptrIn;
    if (strb.doDec)      nextPtr = ptrIn - PW'(1);
    else if (strb.doInc) nextPtr = ptrIn + PW'(1);
  end

  assign accBase  = strb.doDec ? nextPtr : ptrIn;
  assign masked   = accBase & dataMask;
  assign addrNext = strb.useDisp ? (masked + PW'(disp)) : masked;

  assign loIdx     = RW'(PTR_BASE) + RW'({ptrSel, 1'b0});
  assign hiIdx     = loIdx + RW'(1);
  assign hitsPair  = (dataReg[RW-1:1] == loIdx[RW-1:1]);
  assign wideSpace = (dataMask > LOW_SPACE);
  assign adjust    = strb.doDec | strb.doInc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memStrobe <= 1'b0;
      memWrite  <= 1'b0;
      ptrLoData <= '0;
      ptrHiData <= '0;
      ptrLoWe   <= 1'b0;
      ptrHiWe   <= 1'b0;
      ptrLoIdx  <= '0;
      ptrHiIdx  <= '0;
      cycles    <= '0;
      undefOp   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done      <= start;
      memStrobe <= 1'b0;
      ptrLoWe   <= 1'b0;
      ptrHiWe   <= 1'b0;
      undefOp   <= 1'b0;
      if (start) begin
        if (strb.invalid) begin
          undefOp <= 1'b1;
          cycles  <= '0;
        end else begin
          memAddr   <= addrNext;
          memStrobe <= 1'b1;
          memWrite  <= isStore;
          ptrLoData <= nextPtr[7:0];
          ptrHiData <= nextPtr[HB+7:HB];
          ptrLoWe   <= adjust;
          ptrHiWe   <= adjust & wideSpace;
          ptrLoIdx  <= loIdx;
          ptrHiIdx  <= hiIdx;
          cycles    <= strb.cycles;
          undefOp   <= strb.undefChk & hitsPair;
        end
      end
    end
  end

  p_done_follows_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (!done && !memStrobe && !ptrLoWe && !ptrHiWe && !undefOp));
  p_hi_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && dataMask <= LOW_SPACE) |=> !ptrHiWe);
  p_hi_needs_lo_r6: assert property (@(posedge clk) disable iff (!rstN)
    ptrHiWe |-> ptrLoWe);
  p_invalid_no_access_r5: assert property (@(posedge clk) disable iff (!rstN)
    (start && strb.invalid) |=> (!memStrobe && undefOp && $stable(memAddr)));
  p_plain_masked_r1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !strb.invalid && !strb.useDisp) |=> ((memAddr & ~$past(dataMask)) == '0));
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import ptr_addr_pkg::*;
#(
  parameter int PW       = PTR_W,
  parameter int DW       = DISP_W,
  parameter int RW       = RIDX_W,
  parameter int PTR_BASE = 26
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    ptrSel,
  input  logic [1:0]    mode,
  input  logic          isStore,
  input  logic [RW-1:0] dataReg,
  input  logic [PW-1:0] ptrIn,
  input  logic [DW-1:0] disp,
  input  logic [PW-1:0] dataMask,
  input  logic [1:0]    coreVariant,
  output logic [PW-1:0] memAddr,
  output logic          memStrobe,
  output logic          memWrite,
  output logic [7:0]    ptrLoData,
  output logic [7:0]    ptrHiData,
  output logic          ptrLoWe,
  output logic          ptrHiWe,
  output logic [RW-1:0] ptrLoIdx,
  output logic [RW-1:0] ptrHiIdx,
  output logic [1:0]    cycles,
  output logic          undefOp,
  output logic          done
);
  ctrlStrobes_t strb;

  ptr_addr_ctrl #(.CYCW(CYC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .ptrSel(ptrSel),
    .coreVariant(coreVariant), .isStore(isStore), .strb(strb)
  );

  ptr_addr_dp #(
    .PW(PW), .DW(DW), .RW(RW), .CYCW(CYC_W), .PTR_BASE(PTR_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .start(start), .strb(strb), .ptrSel(ptrSel),
    .isStore(isStore), .dataReg(dataReg), .ptrIn(ptrIn), .disp(disp),
    .dataMask(dataMask), .memAddr(memAddr), .memStrobe(memStrobe),
    .memWrite(memWrite), .ptrLoData(ptrLoData), .ptrHiData(ptrHiData),
    .ptrLoWe(ptrLoWe), .ptrHiWe(ptrHiWe), .ptrLoIdx(ptrLoIdx),
    .ptrHiIdx(ptrHiIdx), .cycles(cycles), .undefOp(undefOp), .done(done)
  );
endmodule

// File: tb/tb_ptr_addr_unit.sv
module tb_ptr_addr_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] ptrSel = '0;
  logic [1:0] mode = '0;
  logic isStore = 1'b0;
  logic [4:0] dataReg = '0;
  logic [15:0] ptrIn = '0;
  logic [5:0] disp = '0;
  logic [15:0] dataMask = 16'hFFFF;
  logic [1:0] coreVariant = '0;
  logic [15:0] memAddr;
  logic memStrobe, memWrite, ptrLoWe, ptrHiWe, undefOp, done;
  logic [7:0] ptrLoData, ptrHiData;
  logic [4:0] ptrLoIdx, ptrHiIdx;
  logic [1:0] cycles;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected state
  int eAddr = 0, eStrobe = 0, eWrite = 0, eLo = 0, eHi = 0, eLoWe = 0, eHiWe = 0;
  int eLoIdx = 0, eHiIdx = 0, eCyc = 0, eUndef = 0, eDone = 0;
  string modeTag = "R10";

  ptr_addr_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .ptrSel(ptrSel), .mode(mode),
    .isStore(isStore), .dataReg(dataReg), .ptrIn(ptrIn), .disp(disp),
    .dataMask(dataMask), .coreVariant(coreVariant), .memAddr(memAddr),
    .memStrobe(memStrobe), .memWrite(memWrite), .ptrLoData(ptrLoData),
    .ptrHiData(ptrHiData), .ptrLoWe(ptrLoWe), .ptrHiWe(ptrHiWe),
    .ptrLoIdx(ptrLoIdx), .ptrHiIdx(ptrHiIdx), .cycles(cycles),
    .undefOp(undefOp), .done(done)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk({modeTag, " addr"}, int'(memAddr), eAddr);
    chk({modeTag, " strobe"}, int'(memStrobe), eStrobe);
    chk({modeTag, " write"}, int'(memWrite), eWrite);
    chk({modeTag, " lo data"}, int'(ptrLoData), eLo);
    chk({modeTag, " hi data"}, int'(ptrHiData), eHi);
    chk("R6 lo we", int'(ptrLoWe), eLoWe);
    chk("R6 hi we", int'(ptrHiWe), eHiWe);
    chk("R7 lo idx", int'(ptrLoIdx), eLoIdx);
    chk("R7 hi idx", int'(ptrHiIdx), eHiIdx);
    chk("R9 cycles", int'(cycles), eCyc);
    chk("R8 undef", int'(undefOp), eUndef);
    chk("R10 done", int'(done), eDone);
  endtask

  // behavioural reference for one request
  task automatic model(bit st, int sel, int md, bit wr, int dreg, int p, int d, int msk, int var_);
    bit bad;
    bit red, ext;
    int np, acc;
    eDone = st; eStrobe = 0; eLoWe = 0; eHiWe = 0; eUndef = 0;
    if (!st) begin modeTag = "R10"; return; end
    bad = (sel == 3) || (md == 3 && sel == 0);
    if (bad) begin modeTag = "R5"; eUndef = 1; eCyc = 0; return; end
    red = (var_ == 1); ext = (var_ == 2);
    np = p; acc = p;
    if (md == 1) begin np = (p + 65535) % 65536; acc = np; modeTag = "R2"; end
    else if (md == 2) begin np = (p + 1) % 65536; modeTag = "R3"; end
    else if (md == 3) modeTag = "R4";
    else modeTag = "R1";
    eAddr = acc & msk;
    if (md == 3) eAddr = (eAddr + d) % 65536;
    eStrobe = 1; eWrite = wr;
    eLo = np % 256; eHi = np / 256;
    eLoWe = (md == 1 || md == 2);
    eHiWe = eLoWe && (msk > 255);
    eLoIdx = 26 + 2 * sel; eHiIdx = eLoIdx + 1;
    if (md == 0) eCyc = (red || ext) ? 1 : 2;
    else if (md == 1) eCyc = wr ? 2 : (red ? 3 : 2);
    else if (md == 2) eCyc = wr ? ((red || ext) ? 1 : 2) : (ext ? 1 : 2);
    else eCyc = 2;
    if ((md == 2 || (md == 1 && wr)) && (dreg == eLoIdx || dreg == eHiIdx)) eUndef = 1;
  endtask

  task automatic op(bit st, int sel, int md, bit wr, int dreg, int p, int d, int msk, int var_);
    start = st; ptrSel = 2'(sel); mode = 2'(md); isStore = wr; dataReg = 5'(dreg);
    ptrIn = 16'(p); disp = 6'(d); dataMask = 16'(msk); coreVariant = 2'(var_);
    model(st, sel, md, wr, dreg, p, d, msk, var_);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    modeTag = "R11";
    compareAll();                          // R11 reset state all zero
    rstN = 1'b1;
    op(0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 0);  // R10 idle
    // R1 plain, masking
    op(1, 0, 0, 0, 5, 16'hA5C3, 0, 16'h00DF, 0);
    op(1, 2, 0, 1, 5, 16'h1234, 0, 16'hFFFF, 1);
    // R2 pre-decrement wrap, small space -> no high write (R6)
    op(1, 0, 1, 0, 3, 16'h0000, 0, 16'h00FF, 1);
    op(1, 1, 1, 1, 3, 16'h0100, 0, 16'h01FF, 0);
    // R3 post-increment wrap
    op(1, 2, 2, 0, 3, 16'hFFFF, 0, 16'hFFFF, 2);
    op(1, 0, 2, 1, 3, 16'h7F00, 0, 16'h00FF, 1);
    // R4 offset with carry wrap
    op(1, 1, 3, 0, 3, 16'hFFF0, 63, 16'hFFFF, 0);
    op(1, 2, 3, 1, 3, 16'hFFC0, 7, 16'h00FF, 2);
    // R5 invalid selections
    op(1, 0, 3, 0, 3, 16'h4444, 9, 16'hFFFF, 0);
    op(1, 3, 1, 0, 3, 16'h4444, 9, 16'hFFFF, 0);
    op(0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 0);  // R10 hold
    // R8 undefined-result cases
    op(1, 0, 2, 0, 27, 16'h0010, 0, 16'hFFFF, 0);
    op(1, 1, 1, 1, 28, 16'h0010, 0, 16'hFFFF, 0);
    op(1, 1, 1, 0, 28, 16'h0010, 0, 16'hFFFF, 1);
    op(1, 2, 2, 1, 31, 16'h0010, 0, 16'hFFFF, 2);
    // R9 cycle table sweep
    for (int v = 0; v < 4; v++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 2; w++)
          op(1, 2, m, w[0], 1, 16'h0200, 4, 16'hFFFF, v);
    // randomised traffic, back-to-back and idle gaps
    for (int i = 0; i < 400; i++) begin
      int mk;
      case ($urandom_range(0, 3))
        0: mk = 16'h00FF; 1: mk = 16'h00DF; 2: mk = 16'h01FF; default: mk = 16'hFFFF;
      endcase
      op($urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 3),
         $urandom_range(0, 1), $urandom_range(0, 31), $urandom_range(0, 65535),
         $urandom_range(0, 63), mk, $urandom_range(0, 3));
    end
    rstN = 1'b0;
    eAddr = 0; eStrobe = 0; eWrite = 0; eLo = 0; eHi = 0; eLoWe = 0; eHiWe = 0;
    eLoIdx = 0; eHiIdx = 0; eCyc = 0; eUndef = 0; eDone = 0; modeTag = "R11";
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    compareAll();                          // R11 reset clears outputs
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule